// File: doc/BRIEF.md
# External Bus Read Idle-State Inserter

This block sequences external bus cycles over a memory map split into eight chip-select areas. A requester hands it one access at a time through a valid/ready handshake, giving the target area, a read/write flag and an address. The block then steps the bus through numbered access states. Each area is set up to use either a two-state or a three-state cycle. While a cycle runs, the block drives that area's chip select, the address bus and, for reads, the read strobe.

Some slow memories keep driving the shared data bus for a long time after their read ends. If the next read goes to a different device, the two devices can fight over the bus. To prevent this, the block can place idle states in front of the second read whenever two reads run back to back and target different areas. One global bit enables this feature. The number of idle states comes from one of two shared 2-bit count fields. A per-area select bit picks which field applies, and the bit used is the one belonging to the area of the incoming read.

Top module: `xbus_idle_seq`

## Requirements
- R1: After reset every chip select, the read strobe and done are low, and req_ready is high.
- R2: When idle_en is 0, a read accepted in the final state of a previous read starts its first access state on the very next clock, with no idle state.
- R3: When idle_en is 1, a read accepted in the final state of a previous read to a different area is preceded by idle states.
- R4: A read that follows a read to the same area gets no idle state.
- R5: No idle state is inserted when the previous cycle was a write or when the incoming cycle is a write.
- R6: A request accepted while the bus is idle (no cycle in its final state) starts its first access state on the next clock, with no idle state.
- R7: The idle count comes from the select bit of the incoming read's area: bit value 0 takes field cnt_a, and 1 takes field cnt_b.
- R8: A count field value n (0 to 3) produces exactly n+1 idle states.
- R9: During idle states all chip selects and the read strobe are low, and bus_addr keeps the address of the previous cycle.
- R10: A cycle lasts three access states when three_state[area] is 1 and two states when it is 0.
- R11: During a cycle, only cs[area] is high. For reads, rd is high in every access state except the first. For writes, rd stays low.
- R12: done is high for exactly one clock, in the final access state. req_ready is high in that state and while idle. For a read, rdata holds the bus_data value sampled at the end of that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idle_en | input | 1 | Global enable for idle insertion between reads |
| idle_sel | input | N_AREAS | Per-area choice of count field (0 = cnt_a, 1 = cnt_b) |
| cnt_a | input | IDLE_W | Idle count field A (value n gives n+1 states) |
| cnt_b | input | IDLE_W | Idle count field B (value n gives n+1 states) |
| three_state | input | N_AREAS | Per-area cycle length (1 = three states, 0 = two) |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can accept a request this clock |
| req_area | input | AREA_W | Target area of the request |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | ADDR_W | Request address |
| bus_data | input | DATA_W | Read data from the external data bus |
| cs | output | N_AREAS | Active-high per-area chip selects |
| rd | output | 1 | Active-high read strobe |
| bus_addr | output | ADDR_W | External address bus |
| done | output | 1 | Pulses in the final access state of each cycle |
| rdata | output | DATA_W | Data captured at the end of the last read |

## Verification
The hardest case to reach from the ports is a second request that arrives in exactly the final state of a previous read. Only there can idle states appear. One clock earlier the block is not ready, and one clock later it has already gone idle, which suppresses insertion. To hit that state, the bench holds the second request valid from the clock after the first one is accepted, so the handshake completes on the first ready edge. It also runs paired cases that leave a deliberate gap, to show that an idle bus suppresses insertion. Each case counts the dead clocks between the two chip-select windows, which makes both the idle count and the field selection visible at the ports.

// File: rtl/xbi_pkg.sv
package xbi_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_TI   = 3'd1,
      ST_T1   = 3'd2,
      ST_T2   = 3'd3,
      ST_T3   = 3'd4
   } bus_st_e;
endpackage

// File: rtl/xbi_idle_calc.sv
module xbi_idle_calc #(
   parameter int N_AREAS = 8,
   parameter int IDLE_W  = 2,
   localparam int AREA_W = $clog2(N_AREAS)
) (
   input  logic               idle_en,
   input  logic [N_AREAS-1:0] idle_sel,
   input  logic [IDLE_W-1:0]  cnt_a,
   input  logic [IDLE_W-1:0]  cnt_b,
   input  logic               at_last,
   input  logic [AREA_W-1:0]  prev_area,
   input  logic               prev_write,
   input  logic [AREA_W-1:0]  in_area,
   input  logic               in_write,
   output logic               want_idle,
   output logic [IDLE_W-1:0]  idle_cnt
);
   // field choice follows the incoming area
   always_comb begin
      idle_cnt = idle_sel[in_area] ? cnt_b : cnt_a;
   end

   // insertion only between two reads in different areas, back to back
   always_comb begin
      want_idle = idle_en && at_last && !prev_write && !in_write
                  && (in_area != prev_area);
   end
endmodule

// File: rtl/xbi_seq.sv
module xbi_seq
   import xbi_pkg::*;
#(
   parameter int N_AREAS = 8,
   parameter int IDLE_W  = 2,
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 16,
   localparam int AREA_W = $clog2(N_AREAS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [AREA_W-1:0]  req_area,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [N_AREAS-1:0] three_state,
   input  logic               want_idle,
   input  logic [IDLE_W-1:0]  idle_cnt,
   input  logic [DATA_W-1:0]  bus_data,
   output logic               req_ready,
   output logic               at_last,
   output bus_st_e            state,
   output logic [AREA_W-1:0]  area_q,
   output logic               write_q,
   output logic [ADDR_W-1:0]  bus_addr,
   output logic [DATA_W-1:0]  rdata
);
   logic              three_q;
   logic [IDLE_W-1:0] idle_left;
   logic [ADDR_W-1:0] addr_pend;
   logic              acc;

   always_comb begin
      at_last   = (state == ST_T3) || (state == ST_T2 && !three_q);
      req_ready = (state == ST_IDLE) || at_last;
      acc       = req_valid && req_ready;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         area_q    <= '0;
         write_q   <= 1'b0;
         three_q   <= 1'b0;
         idle_left <= '0;
         addr_pend <= '0;
         bus_addr  <= '0;
         rdata     <= '0;
      end else begin
         if (at_last && !write_q) begin
            rdata <= bus_data;
         end
         if (acc) begin
            area_q    <= req_area;
            write_q   <= req_write;
            three_q   <= three_state[req_area];
            addr_pend <= req_addr;
            if (want_idle) begin
               state     <= ST_TI;
               idle_left <= idle_cnt;
            end else begin
               state    <= ST_T1;
               bus_addr <= req_addr;
            end
         end else begin
            unique case (state)
               ST_IDLE: state <= ST_IDLE;
               ST_TI: begin
                  if (idle_left == '0) begin
                     state    <= ST_T1;
                     bus_addr <= addr_pend;
                  end else begin
                     idle_left <= idle_left - 1'b1;
                  end
               end
               ST_T1:   state <= ST_T2;
               ST_T2:   state <= three_q ? ST_T3 : ST_IDLE;
               ST_T3:   state <= ST_IDLE;
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // R12
   ready_in_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_T1 || state == ST_TI) |-> !req_ready);

   // R10
   two_state_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_T2 && !three_q && !req_valid) |=> (state == ST_IDLE));
endmodule

// File: rtl/xbi_strobe.sv
module xbi_strobe
   import xbi_pkg::*;
#(
   parameter int N_AREAS = 8,
   localparam int AREA_W = $clog2(N_AREAS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  bus_st_e            state,
   input  logic [AREA_W-1:0]  area_q,
   input  logic               write_q,
   input  logic               at_last,
   output logic [N_AREAS-1:0] cs,
   output logic               rd,
   output logic               done
);
   logic active;

   always_comb begin
      active = (state == ST_T1) || (state == ST_T2) || (state == ST_T3);
      rd     = !write_q && ((state == ST_T2) || (state == ST_T3));
      done   = at_last;
   end

   for (genvar i = 0; i < N_AREAS; i++) begin : g_cs
      always_comb begin
         cs[i] = active && (area_q == AREA_W'(i));
      end
   end

   // R11
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs));

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TI) |-> (cs == '0 && !rd));

   // R12
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/xbus_idle_seq.sv
module xbus_idle_seq
   import xbi_pkg::*;
#(
   parameter int N_AREAS = 8,
   parameter int IDLE_W  = 2,
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 16,
   localparam int AREA_W = $clog2(N_AREAS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               idle_en,
   input  logic [N_AREAS-1:0] idle_sel,
   input  logic [IDLE_W-1:0]  cnt_a,
   input  logic [IDLE_W-1:0]  cnt_b,
   input  logic [N_AREAS-1:0] three_state,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [AREA_W-1:0]  req_area,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  bus_data,
   output logic [N_AREAS-1:0] cs,
   output logic               rd,
   output logic [ADDR_W-1:0]  bus_addr,
   output logic               done,
   output logic [DATA_W-1:0]  rdata
);
   if (N_AREAS < 2 || (1 << AREA_W) != N_AREAS) begin : g_bad_areas
      $error("N_AREAS must be a power of two, at least 2");
   end
   if (IDLE_W < 1 || ADDR_W < 1 || DATA_W < 1) begin : g_bad_widths
      $error("IDLE_W, ADDR_W and DATA_W must be positive");
   end

   bus_st_e           state;
   logic [AREA_W-1:0] area_q;
   logic              write_q;
   logic              at_last;
   logic              want_idle;
   logic [IDLE_W-1:0] idle_cnt;

   xbi_idle_calc #(.N_AREAS(N_AREAS), .IDLE_W(IDLE_W)) u_calc (
      .idle_en    (idle_en),
      .idle_sel   (idle_sel),
      .cnt_a      (cnt_a),
      .cnt_b      (cnt_b),
      .at_last    (at_last),
      .prev_area  (area_q),
      .prev_write (write_q),
      .in_area    (req_area),
      .in_write   (req_write),
      .want_idle  (want_idle),
      .idle_cnt   (idle_cnt)
   );

   xbi_seq #(.N_AREAS(N_AREAS), .IDLE_W(IDLE_W), .ADDR_W(ADDR_W),
             .DATA_W(DATA_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_area    (req_area),
      .req_write   (req_write),
      .req_addr    (req_addr),
      .three_state (three_state),
      .want_idle   (want_idle),
      .idle_cnt    (idle_cnt),
      .bus_data    (bus_data),
      .req_ready   (req_ready),
      .at_last     (at_last),
      .state       (state),
      .area_q      (area_q),
      .write_q     (write_q),
      .bus_addr    (bus_addr),
      .rdata       (rdata)
   );

   xbi_strobe #(.N_AREAS(N_AREAS)) u_strobe (
      .clk     (clk),
      .rst_n   (rst_n),
      .state   (state),
      .area_q  (area_q),
      .write_q (write_q),
      .at_last (at_last),
      .cs      (cs),
      .rd      (rd),
      .done    (done)
   );

   // R2
   no_idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !idle_en) |=> (state == ST_T1));

   // R6
   idle_bus_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && state == ST_IDLE) |=> (state == ST_T1));

   // R9
   idle_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TI) |-> $stable(bus_addr));
endmodule

// File: tb/xbus_idle_seq_bench.sv
module xbus_idle_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        idle_en = 1'b0;
   logic [7:0]  idle_sel = 8'b1100_0100;
   logic [1:0]  cnt_a = 2'b00;
   logic [1:0]  cnt_b = 2'b10;
   logic [7:0]  three_state = 8'b0000_1111;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [2:0]  req_area = '0;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] bus_data;
   logic [7:0]  cs;
   logic        rd;
   logic [15:0] bus_addr;
   logic        done;
   logic [15:0] rdata;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign bus_data = bus_addr ^ 16'h5A5A;

   xbus_idle_seq u_xbus_idle_seq (
      .clk(clk), .rst_n(rst_n), .idle_en(idle_en), .idle_sel(idle_sel),
      .cnt_a(cnt_a), .cnt_b(cnt_b), .three_state(three_state),
      .req_valid(req_valid), .req_ready(req_ready), .req_area(req_area),
      .req_write(req_write), .req_addr(req_addr), .bus_data(bus_data),
      .cs(cs), .rd(rd), .bus_addr(bus_addr), .done(done), .rdata(rdata)
   );

   // fields: [13:11] area1, [10] write1, [9:7] area2, [6] write2,
   //         [5:4] gap clocks, [3] idle_en, [2:0] expected idle states
   localparam logic [13:0] VECS [0:NV-1] = '{
      {3'd0, 1'b0, 3'd1, 1'b0, 2'd0, 1'b1, 3'd1},
      {3'd1, 1'b0, 3'd2, 1'b0, 2'd0, 1'b1, 3'd3},
      {3'd3, 1'b0, 3'd3, 1'b0, 2'd0, 1'b1, 3'd0},
      {3'd0, 1'b1, 3'd1, 1'b0, 2'd0, 1'b1, 3'd0},
      {3'd0, 1'b0, 3'd5, 1'b1, 2'd0, 1'b1, 3'd0},
      {3'd4, 1'b0, 3'd6, 1'b0, 2'd1, 1'b1, 3'd0},
      {3'd2, 1'b0, 3'd7, 1'b0, 2'd0, 1'b0, 3'd0},
      {3'd5, 1'b0, 3'd6, 1'b0, 2'd0, 1'b1, 3'd3},
      {3'd6, 1'b0, 3'd0, 1'b0, 2'd0, 1'b1, 3'd1},
      {3'd7, 1'b1, 3'd4, 1'b1, 2'd0, 1'b1, 3'd0}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_pair(input logic [2:0] a1, input logic w1,
                           input logic [2:0] a2, input logic w2,
                           input int gap, input logic en, input int exp_idle);
      logic [15:0] ad1;
      logic [15:0] ad2;
      int len1 = 0, rd1 = 0, off = 0, bad_off = 0, len2 = 0, rd2 = 0;
      int t = 0, k = 0;
      int el1, el2;
      el1 = three_state[a1] ? 3 : 2;
      el2 = three_state[a2] ? 3 : 2;
      ad1 = 16'hA000 | (16'(a1) * 16'h0011);
      ad2 = 16'h3C00 | (16'(a2) * 16'h0101);
      @(negedge clk);
      idle_en = en;
      req_valid = 1'b1; req_area = a1; req_write = w1; req_addr = ad1;
      @(negedge clk);
      if (gap == 0) begin
         req_area = a2; req_write = w2; req_addr = ad2;
      end else begin
         req_valid = 1'b0;
      end
      while (t < 20) begin
         if (cs == (8'd1 << a1)) len1++;
         if (rd) rd1++;
         if (done) break;
         @(negedge clk); t++;
      end
      // R12: ready high in the final state
      chk(req_ready == 1'b1, "R12 ready in last state", int'(req_ready), 1);
      // R10: first cycle length
      chk(len1 == el1, "R10 first cycle length", len1, el1);
      // R11: strobe count of first cycle
      chk(rd1 == (w1 ? 0 : el1 - 1), "R11 first rd states", rd1, w1 ? 0 : el1 - 1);
      t = 0;
      while (t < 20) begin
         @(negedge clk); t++; k++;
         if (cs != 8'd0) break;
         off++;
         if (rd || done || bus_addr != ad1) bad_off++;
         if (gap > 0 && k == gap) begin
            req_valid = 1'b1; req_area = a2; req_write = w2; req_addr = ad2;
         end
      end
      req_valid = 1'b0;
      // R3 R4 R5 R6 R7 R8 R2: dead clocks between the two windows
      chk(off == gap + exp_idle, "R3/R8 idle state count", off, gap + exp_idle);
      // R9: quiet bus with held address during the dead clocks
      chk(bad_off == 0, "R9 idle quiet and address held", bad_off, 0);
      t = 0;
      while (t < 20) begin
         if (cs == (8'd1 << a2)) len2++;
         if (rd) rd2++;
         if (done) break;
         @(negedge clk); t++;
      end
      // R10 R11 second cycle
      chk(len2 == el2, "R10 second cycle length", len2, el2);
      chk(rd2 == (w2 ? 0 : el2 - 1), "R11 second rd states", rd2, w2 ? 0 : el2 - 1);
      chk(bus_addr == ad2, "R11 address of second cycle", int'(bus_addr), int'(ad2));
      @(negedge clk);
      // R12: done gone, read data captured
      chk(done == 1'b0, "R12 done single pulse", int'(done), 0);
      if (!w2) chk(rdata == (ad2 ^ 16'h5A5A), "R12 read data", int'(rdata), int'(ad2 ^ 16'h5A5A));
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(cs == 8'd0 && !rd && !done, "R1 outputs quiet in reset", int'(cs), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs == 8'd0 && !rd && !done, "R1 outputs quiet after reset", int'(cs), 0);
      chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

      for (int i = 0; i < NV; i++) begin
         run_pair(VECS[i][13:11], VECS[i][10], VECS[i][9:7], VECS[i][6],
                  int'(VECS[i][5:4]), VECS[i][3], int'(VECS[i][2:0]));
      end

      // R8: largest field A value gives four idle states
      cnt_a = 2'b11;
      run_pair(3'd0, 1'b0, 3'd1, 1'b0, 0, 1'b1, 4);
      // R7: field B value 01 through area 7's select bit gives two
      cnt_b = 2'b01;
      run_pair(3'd3, 1'b0, 3'd7, 1'b0, 0, 1'b1, 2);
      // R7: select bit of the incoming area, not the outgoing one
      run_pair(3'd7, 1'b0, 3'd3, 1'b0, 0, 1'b1, 4);
      // R6: two clocks of gap, no insertion
      run_pair(3'd1, 1'b0, 3'd2, 1'b0, 2, 1'b1, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule